// File: doc/BRIEF.md
# Multiplexed-Address Page-Mode DRAM Controller

This block lets synchronous logic read and write single bits in a 256K x 1 asynchronous dynamic memory. A host presents an 18-bit address, a direction bit and write data on a valid/ready handshake. The controller sends the address to the memory in two halves over one shared 9-bit address bus: the row half goes out while the row strobe is high and is taken when that strobe falls; the column half follows while the row strobe stays low and is taken when the column strobe falls. Read data is sampled at the end of the column strobe and returned with a one-cycle valid pulse.

After an access the row is left open. A later request to the same row goes straight to the column phase, which is the fast page behaviour of the memory. A request to a different row first raises the row strobe, waits a precharge interval, and then opens the new row. A refresh timer raises a request at a fixed interval. Each refresh closes any open page, drives an internal 8-bit row count on the address bus, pulses only the row strobe, and then advances the count.

Top module: `dram_page_ctrl`

## Requirements
- R1: The request address is split with row = req_addr[17:9] and column = req_addr[8:0]. The row is on mem_addr in the cycle before mem_ras_n falls and in the cycle it falls. The column is on mem_addr in the cycle before mem_cas_n falls and in the cycle it falls. mem_cas_n only falls while mem_ras_n is low.
- R2: For a write (req_we = 1) mem_we_n is low and mem_dq_oe is high with mem_dq_out equal to the request data when mem_cas_n falls. For a read (req_we = 0) mem_we_n is high and mem_dq_oe is low. mem_we_n is steady while mem_cas_n is low.
- R3: A read raises rd_valid for exactly one cycle, with rd_data equal to mem_dq_in as sampled in the last cycle that mem_cas_n is low. At the capture, mem_ras_n has been low for at least T_RAC cycles.
- R4: A request whose row equals the row left open by the previous access, with no refresh in between, issues no new mem_ras_n falling edge.
- R5: A request to a different row, or the first request after reset or after a refresh, starts a new row cycle. Between any rise and the next fall of mem_ras_n, the strobe stays high for at least T_RP cycles.
- R6: A refresh pulses mem_ras_n low while mem_cas_n stays high, with mem_addr = {1'b0, count}. The 8-bit count starts at 0 after reset, goes up by one after each refresh, and wraps from 255 to 0.
- R7: A refresh becomes due every REF_PERIOD cycles and is served before any new request. An open page is closed (mem_ras_n raised plus precharge) before the refresh row strobe.
- R8: After reset mem_ras_n, mem_cas_n and mem_we_n are high, mem_dq_oe and rd_valid are low, and req_ready is high. req_ready is high only when the controller is idle and no refresh is due. It drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Bit address: row in upper half, column in lower half |
| req_wdata | input | 1 | Write data bit |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 1 | Captured read bit |
| mem_addr | output | 9 | Multiplexed row/column address to the memory |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 1 | Data driven to the memory on writes |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | 1 | Data returned by the memory |

## Verification
The bench contains a strobe-level memory model. It catches a row or column swapped in the split, an address that changes at the strobe edge, and a controller that reopens a row on a page hit or reuses a stale row after a page miss or a refresh. Reads and writes sweep the corner rows and columns in two orders, one hit-heavy and one miss-heavy, with data that is a parity function of the address, so a bad capture cycle or a wrong direction bit returns the wrong bit. Idle time runs the refresh count past 255, so a count that does not wrap, skips a value or starts anywhere but zero is reported, and so is a refresh that is served too late behind traffic or that pulses the column strobe.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROWSET,
    ST_RCD,
    ST_COLSET,
    ST_CASL,
    ST_REFSET,
    ST_REF
  } ctl_state_e;
endpackage

// File: rtl/dram_delay.sv
module dram_delay #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // R5: a wait interval is only started once the previous one has run out
  p_reload_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> done);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int REF_PERIOD = 1560,
  parameter int REF_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             pending,
  output logic [REF_W-1:0] ref_row
);
  localparam int PW = $clog2(REF_PERIOD + 1);

  logic [PW-1:0]    tmr_q, tmr_d;
  logic             pend_q, pend_d;
  logic [REF_W-1:0] row_q, row_d;
  logic             tick;

  assign tick = (tmr_q == '0);

  always_comb begin
    tmr_d  = tick ? PW'(REF_PERIOD - 1) : tmr_q - PW'(1);
    pend_d = pend_q;
    if (tick) begin
      pend_d = 1'b1;
    end else if (ref_start) begin
      pend_d = 1'b0;
    end
    row_d = row_q;
    if (ref_done) begin
      row_d = row_q + REF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= PW'(REF_PERIOD - 1);
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign pending = pend_q;
  assign ref_row = row_q;

  // R6: the refresh row count steps by one (mod 256) per completed refresh
  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == $past(ref_row) + REF_W'(1)));

  // R7: an interval expiry always leaves a refresh due
  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pending);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 9,
  parameter int REF_W      = 8,
  parameter int T_RCD      = 3,
  parameter int T_CAS      = 3,
  parameter int T_RP       = 3,
  parameter int T_RAS      = 5,
  parameter int T_RAC      = 7,
  parameter int REF_PERIOD = 1560
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic                                      req_we,
  input  logic [ROW_W+COL_W-1:0]                    req_addr,
  input  logic                                      req_wdata,
  output logic                                      rd_valid,
  output logic                                      rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                                      mem_ras_n,
  output logic                                      mem_cas_n,
  output logic                                      mem_we_n,
  output logic                                      mem_dq_out,
  output logic                                      mem_dq_oe,
  input  logic                                      mem_dq_in
);
  localparam int AW    = ROW_W + COL_W;
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TM_A  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM_B  = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int TMAX  = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int RLW   = $clog2(T_RAC + 1);

  ctl_state_e       state_q, state_d, tgt_q, tgt_d;
  logic             ras_q, ras_d, cas_q, cas_d, we_q, we_d;
  logic             oe_q, oe_d, dout_q, dout_d;
  logic [MA_W-1:0]  ma_q, ma_d;
  logic             page_q, page_d;
  logic [ROW_W-1:0] orow_q, orow_d;
  logic             op_we_q, op_we_d, op_wd_q, op_wd_d;
  logic [AW-1:0]    op_addr_q, op_addr_d;
  logic             rdv_q, rdv_d, rdat_q, rdat_d;

  logic             dly_load, dly_done;
  logic [CW-1:0]    dly_val;
  logic             ref_pend, ref_start, ref_done;
  logic [REF_W-1:0] ref_row;
  logic [ROW_W-1:0] req_row, op_row;
  logic [COL_W-1:0] req_col, op_col;

  assign req_row = req_addr[AW-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign op_row  = op_addr_q[AW-1:COL_W];
  assign op_col  = op_addr_q[COL_W-1:0];

  dram_delay #(.CW(CW)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .done     (dly_done)
  );

  dram_ref_sched #(.REF_PERIOD(REF_PERIOD), .REF_W(REF_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_start (ref_start),
    .ref_done  (ref_done),
    .pending   (ref_pend),
    .ref_row   (ref_row)
  );

  always_comb begin
    state_d   = state_q;
    tgt_d     = tgt_q;
    ras_d     = ras_q;
    cas_d     = cas_q;
    we_d      = we_q;
    oe_d      = oe_q;
    dout_d    = dout_q;
    ma_d      = ma_q;
    page_d    = page_q;
    orow_d    = orow_q;
    op_we_d   = op_we_q;
    op_wd_d   = op_wd_q;
    op_addr_d = op_addr_q;
    rdv_d     = 1'b0;
    rdat_d    = rdat_q;
    dly_load  = 1'b0;
    dly_val   = '0;
    ref_start = 1'b0;
    ref_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_start = 1'b1;
          if (page_q) begin
            ras_d    = 1'b1;
            page_d   = 1'b0;
            tgt_d    = ST_REFSET;
            state_d  = ST_PRE;
            dly_load = 1'b1;
            dly_val  = CW'(T_RP - 1);
          end else begin
            ma_d    = MA_W'(ref_row);
            state_d = ST_REFSET;
          end
        end else if (req_valid) begin
          op_we_d   = req_we;
          op_wd_d   = req_wdata;
          op_addr_d = req_addr;
          if (page_q && (req_row == orow_q)) begin
            ma_d    = MA_W'(req_col);
            we_d    = ~req_we;
            oe_d    = req_we;
            dout_d  = req_wdata;
            state_d = ST_COLSET;
          end else if (page_q) begin
            ras_d    = 1'b1;
            page_d   = 1'b0;
            tgt_d    = ST_ROWSET;
            state_d  = ST_PRE;
            dly_load = 1'b1;
            dly_val  = CW'(T_RP - 1);
          end else begin
            ma_d    = MA_W'(req_row);
            state_d = ST_ROWSET;
          end
        end
      end
      ST_PRE: begin
        if (dly_done) begin
          state_d = tgt_q;
          if (tgt_q == ST_ROWSET) begin
            ma_d = MA_W'(op_row);
          end else if (tgt_q == ST_REFSET) begin
            ma_d = MA_W'(ref_row);
          end
        end
      end
      ST_ROWSET: begin
        ras_d    = 1'b0;
        state_d  = ST_RCD;
        dly_load = 1'b1;
        dly_val  = CW'(T_RCD - 1);
      end
      ST_RCD: begin
        if (dly_done) begin
          ma_d    = MA_W'(op_col);
          we_d    = ~op_we_q;
          oe_d    = op_we_q;
          dout_d  = op_wd_q;
          state_d = ST_COLSET;
        end
      end
      ST_COLSET: begin
        cas_d    = 1'b0;
        state_d  = ST_CASL;
        dly_load = 1'b1;
        dly_val  = CW'(T_CAS - 1);
      end
      ST_CASL: begin
        if (dly_done) begin
          cas_d   = 1'b1;
          we_d    = 1'b1;
          oe_d    = 1'b0;
          page_d  = 1'b1;
          orow_d  = op_row;
          state_d = ST_IDLE;
          if (!op_we_q) begin
            rdv_d  = 1'b1;
            rdat_d = mem_dq_in;
          end
        end
      end
      ST_REFSET: begin
        ras_d    = 1'b0;
        state_d  = ST_REF;
        dly_load = 1'b1;
        dly_val  = CW'(T_RAS - 1);
      end
      ST_REF: begin
        if (dly_done) begin
          ras_d    = 1'b1;
          ref_done = 1'b1;
          tgt_d    = ST_IDLE;
          state_d  = ST_PRE;
          dly_load = 1'b1;
          dly_val  = CW'(T_RP - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= ST_IDLE;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      oe_q      <= 1'b0;
      dout_q    <= 1'b0;
      ma_q      <= '0;
      page_q    <= 1'b0;
      orow_q    <= '0;
      op_we_q   <= 1'b0;
      op_wd_q   <= 1'b0;
      op_addr_q <= '0;
      rdv_q     <= 1'b0;
      rdat_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_q     <= tgt_d;
      ras_q     <= ras_d;
      cas_q     <= cas_d;
      we_q      <= we_d;
      oe_q      <= oe_d;
      dout_q    <= dout_d;
      ma_q      <= ma_d;
      page_q    <= page_d;
      orow_q    <= orow_d;
      op_we_q   <= op_we_d;
      op_wd_q   <= op_wd_d;
      op_addr_q <= op_addr_d;
      rdv_q     <= rdv_d;
      rdat_q    <= rdat_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE) && !ref_pend;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdat_q;
  assign mem_addr   = ma_q;
  assign mem_ras_n  = ras_q;
  assign mem_cas_n  = cas_q;
  assign mem_we_n   = we_q;
  assign mem_dq_out = dout_q;
  assign mem_dq_oe  = oe_q;

  // Cycles the row strobe has been low, saturating; used by the access-time check
  logic [RLW-1:0] ras_low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_low_q <= '0;
    end else if (mem_ras_n) begin
      ras_low_q <= '0;
    end else if (ras_low_q != RLW'(T_RAC)) begin
      ras_low_q <= ras_low_q + RLW'(1);
    end
  end

  p_row_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> $stable(mem_addr));

  p_col_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> ($stable(mem_addr) && !mem_ras_n));

  p_we_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> $stable(mem_we_n));

  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_access_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ras_low_q >= RLW'(T_RAC)));

  p_ref_no_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REF) |-> mem_cas_n);

  p_accept_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_dram_page_ctrl.sv
module sim_dram_page_ctrl;
  localparam int REFP  = 60;
  localparam int TRP   = 3;
  localparam int SLACK = 30;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we, req_wdata;
  logic [17:0] req_addr;
  logic        rd_valid, rd_data;
  logic [8:0]  mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_we_n, mem_dq_out, mem_dq_oe;
  logic        mem_dq_in;

  dram_page_ctrl #(.REF_PERIOD(REFP), .T_RP(TRP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Strobe-level memory model, sampled away from the active edge
  bit          dmem [int];
  logic        pras, pcas;
  logic [8:0]  paddr, m_row;
  bit          m_had_cas, last_new_row;
  int          ras_hi_cnt, ref_cnt, cas_cnt, cyc, last_ref_cyc;
  logic [7:0]  exp_ref;
  logic [17:0] cur_addr;
  bit          cur_we, cur_wd;
  logic        dq_drv;

  assign mem_dq_in = dq_drv;

  initial begin
    pras = 1'b1; pcas = 1'b1; paddr = '0; m_row = '0;
    m_had_cas = 1'b1; last_new_row = 1'b0;
    ras_hi_cnt = 100; ref_cnt = 0; cas_cnt = 0; cyc = 0; last_ref_cyc = 0;
    exp_ref = '0; cur_addr = '0; cur_we = 1'b0; cur_wd = 1'b0; dq_drv = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pras && !mem_ras_n) begin
        chk(mem_addr == paddr, "R1", "row address stable at row strobe", mem_addr, paddr);
        chk(ras_hi_cnt >= TRP, "R5", "row strobe high time", ras_hi_cnt, TRP);
        m_row = mem_addr;
        m_had_cas = 1'b0;
      end
      if (!pras && mem_ras_n) begin
        if (!m_had_cas) begin
          chk(m_row == {1'b0, exp_ref}, "R6", "refresh row", m_row, exp_ref);
          chk(cyc - last_ref_cyc <= REFP + SLACK, "R7", "refresh gap", cyc - last_ref_cyc, REFP + SLACK);
          exp_ref = exp_ref + 8'd1;
          ref_cnt++;
          last_ref_cyc = cyc;
        end
        ras_hi_cnt = 0;
      end
      if (mem_ras_n) ras_hi_cnt++;
      if (pcas && !mem_cas_n) begin
        chk(!mem_ras_n, "R1", "column strobe under row strobe", mem_ras_n, 0);
        chk(mem_addr == paddr, "R1", "column address stable", mem_addr, paddr);
        chk({m_row, mem_addr} == cur_addr, "R1", "address split", {m_row, mem_addr}, cur_addr);
        last_new_row = !m_had_cas;
        m_had_cas = 1'b1;
        cas_cnt++;
        chk(mem_we_n == !cur_we, "R2", "write enable level", mem_we_n, !cur_we);
        if (!mem_we_n) begin
          chk(mem_dq_oe && (mem_dq_out == cur_wd), "R2", "write data driven",
              {mem_dq_oe, mem_dq_out}, {1'b1, cur_wd});
          dmem[int'({m_row, mem_addr})] = mem_dq_out;
        end else begin
          chk(!mem_dq_oe, "R2", "no drive on read", mem_dq_oe, 0);
          dq_drv = dmem.exists(int'({m_row, mem_addr})) ? dmem[int'({m_row, mem_addr})] : 1'b0;
        end
      end
      if (!pcas && mem_cas_n) dq_drv = ~dq_drv;
      pras  = mem_ras_n;
      pcas  = mem_cas_n;
      paddr = mem_addr;
    end
  end

  bit         exp_open;
  logic [8:0] exp_row;
  int         ref_seen;

  function automatic bit pattern(input logic [17:0] a, input bit pass);
    return (^a) ^ pass ^ a[0] ^ a[9];
  endfunction

  task automatic access(input bit we, input logic [17:0] a, input bit wd);
    bit hit;
    int c0, guard;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    cur_addr = a; cur_we = we; cur_wd = wd;
    while (!req_ready) @(negedge clk);
    if (ref_cnt != ref_seen) exp_open = 1'b0;
    hit = exp_open && (exp_row == a[17:9]);
    c0 = cas_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready drops after accept", req_ready, 0);
    guard = 0;
    while (cas_cnt == c0 && guard < 100) begin @(posedge clk); guard++; end
    if (hit) chk(last_new_row == 1'b0, "R4", "page hit reuses row", last_new_row, 0);
    else     chk(last_new_row == 1'b1, "R5", "page miss opens row", last_new_row, 1);
    if (!we) begin
      @(negedge clk);
      guard = 0;
      while (!rd_valid && guard < 50) begin @(negedge clk); guard++; end
      chk(rd_valid && (rd_data == wd), "R3", "read data", {rd_valid, rd_data}, {1'b1, wd});
      @(negedge clk);
      chk(!rd_valid, "R3", "read valid is one cycle", rd_valid, 0);
    end
    exp_open = 1'b1;
    exp_row  = a[17:9];
    ref_seen = ref_cnt;
  endtask

  initial begin
    logic [8:0] rows [4];
    logic [8:0] cols [8];
    int guard;
    rows = '{9'h000, 9'h1FF, 9'h0AA, 9'h155};
    cols = '{9'h000, 9'h001, 9'h1FF, 9'h100, 9'h055, 9'h0AA, 9'h0F0, 9'h10F};
    exp_open = 1'b0; exp_row = '0; ref_seen = 0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: idle levels while in reset
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R8", "strobes high in reset",
        {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rd_valid && req_ready, "R8", "reset outputs",
        {mem_dq_oe, rd_valid, req_ready}, 1);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      // row-major writes: mostly page hits
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c++)
          access(1'b1, {rows[r], cols[c]}, pattern({rows[r], cols[c]}, pass[0]));
      // column-major reads: every access changes row
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 4; r++)
          access(1'b0, {rows[r], cols[c]}, pattern({rows[r], cols[c]}, pass[0]));
      // row-major reads: hits again
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 8; c += 3)
          access(1'b0, {rows[r], cols[c]}, pattern({rows[r], cols[c]}, pass[0]));
    end
    // R6: let the refresh count run past its wrap point
    guard = 0;
    while (ref_cnt < 258 && guard < 40000) begin @(negedge clk); guard++; end
    chk(ref_cnt >= 258, "R6", "refresh count wrapped", ref_cnt, 258);
    chk(exp_ref == 8'(ref_cnt), "R6", "refresh row after wrap", exp_ref, 8'(ref_cnt));
    // after refreshes the page is closed: next access must open a row
    access(1'b0, {rows[0], cols[0]}, pattern({rows[0], cols[0]}, 1'b1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule